// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit physical address for a 16-bit processor whose linear address space is cut into 64K banks, each bank named by the top address byte. On each request it takes an addressing mode, a 16-bit operand, a choice of index register, the bank registers (data, program and a bank byte carried in the instruction), the direct-page base, the stack pointer and the emulation flag. One clock later it returns the address together with the class of access.

The access classes do not share one bank rule. Data addresses built from a bank register may carry into the next bank when an index is added. Instruction fetch, direct-page, stack and vector accesses stay inside a single bank and wrap at 16 bits. For the modes that change the program bank (vector entry and far transfer), the block also reports the new program-bank value so that the surrounding core can load its register. Instruction decoding and arithmetic are left to other blocks.

Top module: `bank_ea_gen`

## Requirements
- R1: While reset (`rstN` low) is applied and in the cycle after it, `outValid`, `physAddr`, `accClass`, `pbWe` and `pbNext` are all zero.
- R2: Mode 0 (fetch) gives `{progBank, (operand + index) mod 2^16}` with class 0 (fetch): the offset wraps and the bank never changes.
- R3: In emulation mode (`emuMode`=1), a fetch (mode 0) or a far transfer (mode 6) uses bank 0, and a far transfer reports `pbNext`=0.
- R4: Mode 1 (absolute) gives `({dataBank, operand} + index) mod 2^24` with class 1 (data), so indexing carries into the next bank.
- R5: Mode 2 (long) gives `({longBank, operand} + index) mod 2^24` with class 1, which wraps from 0xFFFFFF to 0x000000.
- R6: Mode 3 (direct page) gives `{8'h00, (directBase + operand + index) mod 2^16}` with class 1, whatever the data bank holds.
- R7: Mode 4 (stack) gives `{8'h00, (stackPtr + operand) mod 2^16}` with class 2 (stack). The index choice is ignored.
- R8: Mode 5 (vector) gives `{8'h00, operand}` with class 3 (vector), `pbWe`=1 and `pbNext`=0.
- R9: Mode 6 (far transfer) gives `{longBank, operand}` with class 0, `pbWe`=1 and `pbNext`=`longBank`. The index choice is ignored.
- R10: `idxSel` 1 selects `idxX`, 2 selects `idxY`, and 0 or 3 adds nothing.
- R11: Mode 7 (reserved) behaves exactly like mode 1.
- R12: `pbWe` is 0 for every mode except 5 and 6.
- R13: The outputs describe the request presented one clock earlier: `outValid` equals the `reqValid` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code (0..7) |
| operand | input | 16 | Operand or offset |
| idxSel | input | 2 | Index choice: 0 none, 1 X, 2 Y, 3 none |
| idxX | input | 16 | X index register |
| idxY | input | 16 | Y index register |
| dataBank | input | 8 | Data bank register |
| progBank | input | 8 | Program bank register |
| longBank | input | 8 | Bank byte carried in the instruction |
| directBase | input | 16 | Direct-page base register |
| stackPtr | input | 16 | Stack pointer |
| emuMode | input | 1 | Emulation-mode flag |
| outValid | output | 1 | Result valid |
| physAddr | output | 24 | Physical address |
| accClass | output | 2 | 0 fetch, 1 data, 2 stack, 3 vector |
| pbWe | output | 1 | Program-bank load request |
| pbNext | output | 8 | New program-bank value |

## Verification
The bench builds the block with the default widths: an 8-bit bank and a 16-bit offset. At these widths, operands near 0xFFFF can be combined with small index values to reach both wrap points: the 16-bit wrap inside a bank and the carry into the next bank. A long address near 0xFFFFFF also reaches the full 24-bit wrap. Directed cases sit on these edges for every mode, with and without emulation. Random absolute, long and direct-page requests then check that the carry and wrap rules hold apart from the edges.

// File: rtl/bank_ea_pkg.sv
package bank_ea_pkg;

  typedef enum logic [2:0] {
    MODE_FETCH  = 3'd0,
    MODE_ABS    = 3'd1,
    MODE_LONG   = 3'd2,
    MODE_DIRECT = 3'd3,
    MODE_STACK  = 3'd4,
    MODE_VECTOR = 3'd5,
    MODE_FAR    = 3'd6,
    MODE_RSVD   = 3'd7
  } eaMode_e;

  typedef enum logic [1:0] {
    CLS_FETCH  = 2'd0,
    CLS_DATA   = 2'd1,
    CLS_STACK  = 2'd2,
    CLS_VECTOR = 2'd3
  } accClass_e;

  typedef enum logic [1:0] {
    BK_ZERO = 2'd0,
    BK_PROG = 2'd1,
    BK_DATA = 2'd2,
    BK_LONG = 2'd3
  } bankSel_e;

  typedef enum logic [1:0] {
    BASE_NONE   = 2'd0,
    BASE_DIRECT = 2'd1,
    BASE_STACK  = 2'd2
  } baseSel_e;

  typedef enum logic [1:0] {
    IX_NONE = 2'd0,
    IX_X    = 2'd1,
    IX_Y    = 2'd2
  } idxPick_e;

  typedef struct packed {
    bankSel_e  bankSel;
    baseSel_e  baseSel;
    idxPick_e  idxPick;
    logic      carryWide;
    logic      pbLoad;
    logic      pbFromLong;
    accClass_e cls;
  } eaStrobes_t;

endpackage

// File: rtl/bank_ea_ctrl.sv
module bank_ea_ctrl
  import bank_ea_pkg::*;
(
  input  logic [2:0] modeIn,
  input  logic [1:0] idxSelIn,
  input  logic       emuMode,
  output eaStrobes_t strb
);

  idxPick_e reqPick;

  always_comb begin
    case (idxSelIn)
      2'd1:    reqPick = IX_X;
      2'd2:    reqPick = IX_Y;
      default: reqPick = IX_NONE;
    endcase
  end

  always_comb begin
    strb.bankSel    = BK_DATA;
    strb.baseSel    = BASE_NONE;
    strb.idxPick    = reqPick;
    strb.carryWide  = 1'b1;
    strb.pbLoad     = 1'b0;
    strb.pbFromLong = 1'b0;
    strb.cls        = CLS_DATA;
    case (eaMode_e'(modeIn))
      MODE_FETCH: begin
        strb.bankSel   = emuMode ? BK_ZERO : BK_PROG;
        strb.carryWide = 1'b0;
        strb.cls       = CLS_FETCH;
      end
      MODE_LONG: begin
        strb.bankSel = BK_LONG;
      end
      MODE_DIRECT: begin
        strb.bankSel   = BK_ZERO;
        strb.baseSel   = BASE_DIRECT;
        strb.carryWide = 1'b0;
      end
      MODE_STACK: begin
        strb.bankSel   = BK_ZERO;
        strb.baseSel   = BASE_STACK;
        strb.idxPick   = IX_NONE;
        strb.carryWide = 1'b0;
        strb.cls       = CLS_STACK;
      end
      MODE_VECTOR: begin
        strb.bankSel   = BK_ZERO;
        strb.idxPick   = IX_NONE;
        strb.carryWide = 1'b0;
        strb.pbLoad    = 1'b1;
        strb.cls       = CLS_VECTOR;
      end
      MODE_FAR: begin
        strb.bankSel    = emuMode ? BK_ZERO : BK_LONG;
        strb.idxPick    = IX_NONE;
        strb.carryWide  = 1'b0;
        strb.pbLoad     = 1'b1;
        strb.pbFromLong = !emuMode;
        strb.cls        = CLS_FETCH;
      end
      default: ; // absolute and reserved codes keep the defaults
    endcase
  end

  // R12
  always_comb begin
    pb_load_class_chk: assert (!strb.pbLoad || strb.cls == CLS_FETCH || strb.cls == CLS_VECTOR);
  end

  // R3
  always_comb begin
    emu_bank_chk: assert (!(emuMode && strb.cls == CLS_FETCH) || strb.bankSel == BK_ZERO);
  end

endmodule

// File: rtl/bank_ea_dpath.sv
module bank_ea_dpath
  import bank_ea_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  eaStrobes_t                  strb,
  input  logic [OFF_W-1:0]            operand,
  input  logic [OFF_W-1:0]            idxX,
  input  logic [OFF_W-1:0]            idxY,
  input  logic [BANK_W-1:0]           dataBank,
  input  logic [BANK_W-1:0]           progBank,
  input  logic [BANK_W-1:0]           longBank,
  input  logic [OFF_W-1:0]            directBase,
  input  logic [OFF_W-1:0]            stackPtr,
  output logic                        outValid,
  output logic [BANK_W+OFF_W-1:0]     physAddr,
  output logic [1:0]                  accClass,
  output logic                        pbWe,
  output logic [BANK_W-1:0]           pbNext
);

  localparam int ADDR_W = BANK_W + OFF_W;

  logic [BANK_W-1:0] bankVal;
  logic [OFF_W-1:0]  baseVal;
  logic [OFF_W-1:0]  baseOff;
  logic [OFF_W-1:0]  idxVal;
  logic [OFF_W-1:0]  sumWrap;
  logic [ADDR_W-1:0] sumWide;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    case (strb.bankSel)
      BK_PROG: bankVal = progBank;
      BK_DATA: bankVal = dataBank;
      BK_LONG: bankVal = longBank;
      default: bankVal = '0;
    endcase
    case (strb.baseSel)
      BASE_DIRECT: baseVal = directBase;
      BASE_STACK:  baseVal = stackPtr;
      default:     baseVal = '0;
    endcase
    case (strb.idxPick)
      IX_X:    idxVal = idxX;
      IX_Y:    idxVal = idxY;
      default: idxVal = '0;
    endcase
  end

  assign baseOff  = operand + baseVal;
  assign sumWrap  = baseOff + idxVal;
  assign sumWide  = {bankVal, baseOff} + {{BANK_W{1'b0}}, idxVal};
  assign nextAddr = strb.carryWide ? sumWide : {bankVal, sumWrap};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      physAddr <= '0;
      accClass <= CLS_FETCH;
      pbWe     <= 1'b0;
      pbNext   <= '0;
    end else begin
      outValid <= reqValid;
      pbWe     <= reqValid && strb.pbLoad;
      if (reqValid) begin
        physAddr <= nextAddr;
        accClass <= strb.cls;
        pbNext   <= strb.pbFromLong ? longBank : '0;
      end
    end
  end

  // R13
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  // R13
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R6
  zero_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strb.bankSel == BK_ZERO) |=> (physAddr[ADDR_W-1:OFF_W] == '0));

  // R2
  fetch_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strb.bankSel == BK_PROG) |=> (physAddr[ADDR_W-1:OFF_W] == $past(progBank)));

  // R8
  vector_pb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && accClass == CLS_VECTOR) |-> (pbWe && pbNext == '0));

  // R4
  abs_plain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strb.bankSel == BK_DATA && strb.idxPick == IX_NONE)
      |=> (physAddr == {$past(dataBank), $past(operand)}));

endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
  import bank_ea_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [2:0]              mode,
  input  logic [OFF_W-1:0]        operand,
  input  logic [1:0]              idxSel,
  input  logic [OFF_W-1:0]        idxX,
  input  logic [OFF_W-1:0]        idxY,
  input  logic [BANK_W-1:0]       dataBank,
  input  logic [BANK_W-1:0]       progBank,
  input  logic [BANK_W-1:0]       longBank,
  input  logic [OFF_W-1:0]        directBase,
  input  logic [OFF_W-1:0]        stackPtr,
  input  logic                    emuMode,
  output logic                    outValid,
  output logic [BANK_W+OFF_W-1:0] physAddr,
  output logic [1:0]              accClass,
  output logic                    pbWe,
  output logic [BANK_W-1:0]       pbNext
);

  eaStrobes_t strb;

  bank_ea_ctrl u_ctrl (
    .modeIn   (mode),
    .idxSelIn (idxSel),
    .emuMode  (emuMode),
    .strb     (strb)
  );

  bank_ea_dpath #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .strb       (strb),
    .operand    (operand),
    .idxX       (idxX),
    .idxY       (idxY),
    .dataBank   (dataBank),
    .progBank   (progBank),
    .longBank   (longBank),
    .directBase (directBase),
    .stackPtr   (stackPtr),
    .outValid   (outValid),
    .physAddr   (physAddr),
    .accClass   (accClass),
    .pbWe       (pbWe),
    .pbNext     (pbNext)
  );

endmodule

// File: tb/tb_bank_ea_gen.sv
`timescale 1ns/1ps
module tb_bank_ea_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] operand = '0;
  logic [1:0]  idxSel = '0;
  logic [15:0] idxX = '0, idxY = '0;
  logic [7:0]  dataBank = '0, progBank = '0, longBank = '0;
  logic [15:0] directBase = '0, stackPtr = '0;
  logic        emuMode = 1'b0;
  logic        outValid;
  logic [23:0] physAddr;
  logic [1:0]  accClass;
  logic        pbWe;
  logic [7:0]  pbNext;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [23:0] addr;
    logic [1:0]  cls;
    logic        we;
    logic [7:0]  pbn;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  bank_ea_gen dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .operand(operand),
    .idxSel(idxSel), .idxX(idxX), .idxY(idxY), .dataBank(dataBank),
    .progBank(progBank), .longBank(longBank), .directBase(directBase),
    .stackPtr(stackPtr), .emuMode(emuMode), .outValid(outValid),
    .physAddr(physAddr), .accClass(accClass), .pbWe(pbWe), .pbNext(pbNext)
  );

  function automatic expItem_t refModel(input logic [2:0] m, input logic [15:0] op,
      input logic [1:0] sel, input logic [15:0] x, input logic [15:0] y,
      input logic [7:0] db, input logic [7:0] pb, input logic [7:0] lb,
      input logic [15:0] dp, input logic [15:0] sp, input logic emu, input string tag);
    expItem_t e;
    int unsigned ix;
    int unsigned full;
    ix = (sel == 2'd1) ? x : (sel == 2'd2) ? y : 0;
    e.we = 1'b0; e.pbn = 8'h00; e.cls = 2'd1; e.tag = tag;
    case (m)
      3'd0: begin
        full = ((emu ? 0 : int'(pb)) << 16) | ((int'(op) + ix) & 32'hFFFF);
        e.cls = 2'd0;
      end
      3'd2: full = ((int'(lb) << 16) + int'(op) + ix) & 32'hFF_FFFF;
      3'd3: full = (int'(dp) + int'(op) + ix) & 32'hFFFF;
      3'd4: begin full = (int'(sp) + int'(op)) & 32'hFFFF; e.cls = 2'd2; end
      3'd5: begin full = int'(op); e.cls = 2'd3; e.we = 1'b1; e.pbn = 8'h00; end
      3'd6: begin
        full = ((emu ? 0 : int'(lb)) << 16) | int'(op);
        e.cls = 2'd0; e.we = 1'b1; e.pbn = emu ? 8'h00 : lb;
      end
      default: full = ((int'(db) << 16) + int'(op) + ix) & 32'hFF_FFFF;
    endcase
    e.addr = full[23:0];
    return e;
  endfunction

  task automatic send(input logic [2:0] m, input logic [15:0] op, input logic [1:0] sel,
      input logic [15:0] x, input logic [15:0] y, input logic [7:0] db,
      input logic [7:0] pb, input logic [7:0] lb, input logic [15:0] dp,
      input logic [15:0] sp, input logic emu, input string tag);
    @(negedge clk);
    reqValid = 1'b1; mode = m; operand = op; idxSel = sel; idxX = x; idxY = y;
    dataBank = db; progBank = pb; longBank = lb; directBase = dp; stackPtr = sp;
    emuMode = emu;
    expQ.push_back(refModel(m, op, sel, x, y, db, pb, lb, dp, sp, emu, tag));
  endtask

  task automatic idleCheck();
    @(negedge clk);
    reqValid = 1'b0;
    mode = 3'd5;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || pbWe !== 1'b0) begin
      errors++;
      $display("FAIL R13 idle: outValid=%b pbWe=%b expected 0 0", outValid, pbWe);
    end
  endtask

  // monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (rstN && outValid === 1'b1) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected output addr=%h expected no output", physAddr);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (physAddr !== e.addr || accClass !== e.cls || pbWe !== e.we || pbNext !== e.pbn) begin
          errors++;
          $display("FAIL %s: addr=%h cls=%0d we=%b pbn=%h expected addr=%h cls=%0d we=%b pbn=%h",
                   e.tag, physAddr, accClass, pbWe, pbNext, e.addr, e.cls, e.we, e.pbn);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, reset still asserted
    checks++;
    if (outValid !== 1'b0 || physAddr !== 24'h0 || accClass !== 2'd0 || pbWe !== 1'b0 || pbNext !== 8'h0) begin
      errors++;
      $display("FAIL R1 reset: valid=%b addr=%h cls=%0d we=%b pbn=%h expected all zero",
               outValid, physAddr, accClass, pbWe, pbNext);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || physAddr !== 24'h0) begin
      errors++;
      $display("FAIL R1 after reset: valid=%b addr=%h expected 0 000000", outValid, physAddr);
    end

    //    mode  operand   sel  X        Y        db     pb     lb     dp        sp        emu
    send(3'd0, 16'hFFFE, 2'd1, 16'h0005, 16'h0, 8'h12, 8'h34, 8'h56, 16'h0, 16'h0, 1'b0, "R2 fetch wraps in bank");
    send(3'd0, 16'h8000, 2'd0, 16'h0, 16'h0, 8'h12, 8'hC3, 8'h56, 16'h0, 16'h0, 1'b0, "R2 fetch plain");
    send(3'd0, 16'h1234, 2'd2, 16'h0, 16'h0010, 8'h12, 8'h7E, 8'h56, 16'h0, 16'h0, 1'b1, "R3 emu fetch bank 0");
    send(3'd6, 16'h4000, 2'd0, 16'h0, 16'h0, 8'h12, 8'h34, 8'h9A, 16'h0, 16'h0, 1'b1, "R3 emu far bank 0");
    send(3'd1, 16'hFFF0, 2'd1, 16'h0020, 16'h0, 8'h12, 8'h34, 8'h56, 16'h0, 16'h0, 1'b0, "R4 abs carries to next bank");
    send(3'd1, 16'hFFFF, 2'd2, 16'h0, 16'hFFFF, 8'hFF, 8'h34, 8'h56, 16'h0, 16'h0, 1'b0, "R4 abs top of space wraps");
    send(3'd2, 16'hFFFF, 2'd2, 16'h0, 16'h0002, 8'h12, 8'h34, 8'hFF, 16'h0, 16'h0, 1'b0, "R5 long 24-bit wrap");
    send(3'd2, 16'h8000, 2'd1, 16'h9000, 16'h0, 8'h12, 8'h34, 8'h20, 16'h0, 16'h0, 1'b0, "R5 long carry");
    send(3'd3, 16'h00F0, 2'd1, 16'h0020, 16'h0, 8'h77, 8'h34, 8'h56, 16'hFF00, 16'h0, 1'b0, "R6 direct wraps in bank 0");
    send(3'd3, 16'h0010, 2'd2, 16'h0, 16'h0003, 8'h77, 8'h34, 8'h56, 16'h2000, 16'h0, 1'b0, "R6 direct plain");
    send(3'd4, 16'h0020, 2'd1, 16'h5555, 16'h0, 8'h77, 8'h34, 8'h56, 16'h0, 16'h01F0, 1'b0, "R7 stack ignores index");
    send(3'd4, 16'h0020, 2'd0, 16'h0, 16'h0, 8'h77, 8'h34, 8'h56, 16'h0, 16'hFFF0, 1'b0, "R7 stack wraps in bank 0");
    send(3'd5, 16'hFFFE, 2'd1, 16'h1111, 16'h0, 8'h77, 8'h34, 8'h56, 16'h0, 16'h0, 1'b0, "R8 vector bank 0");
    send(3'd6, 16'h1234, 2'd1, 16'h1111, 16'h0, 8'h77, 8'h34, 8'h5A, 16'h0, 16'h0, 1'b0, "R9 far transfer");
    send(3'd1, 16'h1000, 2'd3, 16'h0100, 16'h0200, 8'h40, 8'h34, 8'h56, 16'h0, 16'h0, 1'b0, "R10 sel 3 adds nothing");
    send(3'd1, 16'h1000, 2'd2, 16'h0100, 16'h0200, 8'h40, 8'h34, 8'h56, 16'h0, 16'h0, 1'b0, "R10 sel 2 picks Y");
    send(3'd7, 16'hFFFF, 2'd1, 16'h0001, 16'h0, 8'h3C, 8'h34, 8'h56, 16'h0, 16'h0, 1'b0, "R11 reserved as absolute");
    send(3'd3, 16'h0001, 2'd0, 16'h0, 16'h0, 8'h3C, 8'h34, 8'h56, 16'h0, 16'h0, 1'b1, "R12 no bank load for direct");
    idleCheck();

    for (int i = 0; i < 60; i++) begin
      logic [2:0] m;
      string tg;
      m = (i % 3 == 0) ? 3'd1 : (i % 3 == 1) ? 3'd2 : 3'd3;
      tg = (m == 3'd1) ? "R4 random abs" : (m == 3'd2) ? "R5 random long" : "R6 random direct";
      send(m, 16'($urandom), 2'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
           8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), tg);
    end
    idleCheck();
    repeat (3) @(negedge clk);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R13 missing outputs: %0d pending expected 0", expQ.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule